// File: doc/BRIEF.md
# Retriggerable Watchdog Timer with Power-On Mode Window

This block is a watchdog counter for a small processor. Software starts it with a single-cycle strobe that stands for the watchdog instruction. Each later strobe restarts the count. If the count reaches the selected terminal value before a strobe arrives, the block raises a one-cycle reset request to the processor. It then disarms itself, and the software that restarts must strobe it again.

A five-bit mode register sets four things: the terminal count (tap), whether counting continues while the processor sits in HALT, whether it continues while the processor sits in STOP, and which of two clock-enable inputs advances the counter. One enable stands for an on-chip RC oscillator and the other for the crystal. After each power-on reset the register accepts writes for a short window only. After that window it is frozen until the next power-on reset. The reset request does not clear the mode register.

Top module: `wdt_timer`

## Requirements
- R1: While rst_n is low, and in the cycle after it, mode_rd_data reads 8'hED (tap code 01, halt-run 1, stop-run 1, source 0, upper bits 1), reset_req is 0 and the counter is disarmed.
- R2: Until the first wdt_strobe after reset, no tick of either source produces reset_req.
- R3: A wdt_strobe arms the counter and sets the count to zero. In a cycle with both a strobe and a qualifying tick, the strobe wins, so reset_req stays 0 in the next cycle.
- R4: reset_req is high for exactly one cycle, in the cycle after the edge that counts the Nth qualifying tick since the last strobe. That edge also disarms the counter and zeroes the count, so later ticks give no further request.
- R5: mode bits [1:0] pick N. Tap codes 00, 01, 10 and 11 give 256, 512, 1024 and 4096 ticks for the crystal source, and 50, 150, 250 and 1000 ticks for the RC source (default parameters).
- R6: mode bit 4 picks the source. With 0 only rc_tick advances the count, and with 1 only xtal_tick does.
- R7: mode bit 2 at 0 makes a tick with halt_mode high count nothing. At 1, HALT does not gate the count.
- R8: mode bit 3 at 0 makes a tick with stop_mode high count nothing. At 1, STOP does not gate the count.
- R9: Writes to the mode register take effect only at clock edges 0 through 63. Edge 0 is the first edge with rst_n high. A write at edge 64 or later leaves mode_rd_data unchanged.
- R10: mode_rd_data[7:5] always reads 3'b111. Written values of bits 7:5 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wdt_strobe | input | 1 | Watchdog instruction strobe: arms the counter and restarts it |
| mode_wr_en | input | 1 | Mode register write enable |
| mode_wr_data | input | 8 | Mode register write data |
| mode_rd_data | output | 8 | Mode register read value |
| halt_mode | input | 1 | Processor is in HALT |
| stop_mode | input | 1 | Processor is in STOP |
| rc_tick | input | 1 | Clock enable from the RC oscillator domain |
| xtal_tick | input | 1 | Clock enable from the crystal domain |
| reset_req | output | 1 | One-cycle reset request to the processor |

## Verification
The two functions that can fall in the same cycle are the restart strobe and the tick that would complete the terminal count. The strobe must win, so no reset request may appear. A directed case arms the counter with the shortest crystal tap and ticks every cycle. It then raises the strobe together with the 256th tick and checks that reset_req stays low. It also checks that a fresh full count is then needed. Random runs also let strobes land on terminal ticks. A cycle-level bench model judges every cycle, and it also covers a mode write that arrives in the same cycle as a counted tick: the count uses the old mode.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
// Package wdt_pkg
// Shared mode-register layout, its reset value and helper functions for the watchdog.
// Assumes the bit positions below are visible to software and must not move.
package wdt_pkg;

    // Mode layout, MSB first: source select, stop-run, halt-run, tap code.
    typedef struct packed {
        logic       src_xtal;
        logic       stop_run;
        logic       halt_run;
        logic [1:0] tap;
    } wdt_mode_t;

    localparam int MODE_BITS = 5;
    localparam wdt_mode_t MODE_RESET = '{src_xtal: 1'b0, stop_run: 1'b1,
                                         halt_run: 1'b1, tap: 2'b01};

    // Largest of four tap lengths; sizes the counter.
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdt_mode_reg.sv
`timescale 1ns/1ps
// Module wdt_mode_reg
// Holds the watchdog mode. It accepts writes only while a post-reset cycle counter is
// below WINDOW, then freezes. Assumes rst_n is the power-on reset and nothing else.
module wdt_mode_reg
    import wdt_pkg::*;
#(
    parameter int WINDOW = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output wdt_mode_t   mode,
    output logic [7:0]  rd_data
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    logic [WIN_W-1:0] win_cnt;
    logic             win_open;
    logic             unused_hi;

    assign win_open  = (win_cnt < WIN_W'(WINDOW));
    assign unused_hi = ^wr_data[7:MODE_BITS];
    assign rd_data   = {{(8-MODE_BITS){1'b1}}, mode};

    // Count edges since reset, saturating once the window has closed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (win_open)
            win_cnt <= win_cnt + 1'b1;
    end

    // Load the mode on writes inside the window; otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_RESET;
        else if (win_open && wr_en)
            mode <= wdt_mode_t'(wr_data[MODE_BITS-1:0]);
    end

endmodule

// File: rtl/wdt_advance.sv
`timescale 1ns/1ps
// Module wdt_advance
// Combinational qualifier. It decides whether this cycle carries a tick that may advance
// the count, using the selected source and the HALT/STOP run permissions.
// Assumes the tick inputs are single-cycle enables already in the clk domain.
module wdt_advance
    import wdt_pkg::*;
(
    input  wdt_mode_t mode,
    input  logic      rc_tick,
    input  logic      xtal_tick,
    input  logic      halt_mode,
    input  logic      stop_mode,
    output logic      advance
);
    logic src_tick;
    logic run_ok;

    // Pick the tick source and apply the low-power gating.
    always_comb begin
        src_tick = mode.src_xtal ? xtal_tick : rc_tick;
        run_ok   = (!halt_mode || mode.halt_run) && (!stop_mode || mode.stop_run);
        advance  = src_tick && run_ok;
    end

endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
// Module wdt_counter
// Retriggerable one-shot counter. A strobe arms it and zeroes it. Each qualified advance
// adds one. On reaching the selected terminal length it emits a one-cycle request and disarms.
// Assumes every tap length is at least 2.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int XT_TAP [4] = '{256, 512, 1024, 4096},
    parameter int RC_TAP [4] = '{50, 150, 250, 1000}
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe,
    input  logic      advance,
    input  wdt_mode_t mode,
    output logic      req
);
    localparam int MAX_TAP = max_of4(max_of4(XT_TAP[0], XT_TAP[1], XT_TAP[2], XT_TAP[3]),
                                     max_of4(RC_TAP[0], RC_TAP[1], RC_TAP[2], RC_TAP[3]),
                                     1, 1);
    localparam int CNT_W   = $clog2(MAX_TAP + 1);

    logic [CNT_W-1:0] last_tbl [8];
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] count;
    logic             armed;

    // Last-count table: entries 0..3 for the RC source, 4..7 for the crystal.
    for (genvar i = 0; i < 4; i++) begin : g_tbl
        assign last_tbl[i]     = CNT_W'(RC_TAP[i] - 1);
        assign last_tbl[4 + i] = CNT_W'(XT_TAP[i] - 1);
    end

    assign last_val = last_tbl[{mode.src_xtal, mode.tap}];

    // Arm/restart on strobe; count qualified ticks; fire and disarm at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            count <= '0;
            req   <= 1'b0;
        end else begin
            req <= 1'b0;
            if (strobe) begin
                armed <= 1'b1;
                count <= '0;
            end else if (armed && advance) begin
                if (count == last_val) begin
                    req   <= 1'b1;
                    armed <= 1'b0;
                    count <= '0;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdt_timer.sv
`timescale 1ns/1ps
// Module wdt_timer (top)
// Watchdog with a post-reset write window for its mode, tick-source and tap selection,
// HALT/STOP gating and a single-cycle reset request.
// Assumes all inputs are synchronous to clk. The reset request does not clear the mode.
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int WINDOW     = 64,
    parameter int XT_TAP [4] = '{256, 512, 1024, 4096},
    parameter int RC_TAP [4] = '{50, 150, 250, 1000}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wdt_strobe,
    input  logic       mode_wr_en,
    input  logic [7:0] mode_wr_data,
    output logic [7:0] mode_rd_data,
    input  logic       halt_mode,
    input  logic       stop_mode,
    input  logic       rc_tick,
    input  logic       xtal_tick,
    output logic       reset_req
);
    wdt_mode_t mode;
    logic      advance;

    wdt_mode_reg #(.WINDOW(WINDOW)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode    (mode),
        .rd_data (mode_rd_data)
    );

    wdt_advance u_adv (
        .mode      (mode),
        .rc_tick   (rc_tick),
        .xtal_tick (xtal_tick),
        .halt_mode (halt_mode),
        .stop_mode (stop_mode),
        .advance   (advance)
    );

    wdt_counter #(.XT_TAP(XT_TAP), .RC_TAP(RC_TAP)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (wdt_strobe),
        .advance (advance),
        .mode    (mode),
        .req     (reset_req)
    );

endmodule

// File: rtl/wdt_checks.sv
`timescale 1ns/1ps
// Module wdt_checks
// Port-level properties of wdt_timer, attached with bind. It keeps its own
// post-reset cycle counter for the write-window check.
module wdt_checks #(
    parameter int WINDOW = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wdt_strobe,
    input logic       halt_mode,
    input logic       stop_mode,
    input logic [7:0] mode_rd_data,
    input logic       reset_req
);
    localparam int CW = $clog2(WINDOW + 2);
    logic [CW-1:0] since_rst;

    // Count edges since reset release, saturating just past the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst <= CW'(WINDOW))
            since_rst <= since_rst + 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!reset_req && mode_rd_data == 8'hED));

    assert_strobe_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_strobe |=> !reset_req);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    assert_halt_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_mode && !mode_rd_data[2]) |=> !reset_req);

    assert_stop_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !mode_rd_data[3]) |=> !reset_req);

    assert_window_shut_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= CW'(WINDOW)) |=> $stable(mode_rd_data));

    assert_upper_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd_data[7:5] == 3'b111);

endmodule

bind wdt_timer wdt_checks #(.WINDOW(WINDOW)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdt_strobe   (wdt_strobe),
    .halt_mode    (halt_mode),
    .stop_mode    (stop_mode),
    .mode_rd_data (mode_rd_data),
    .reset_req    (reset_req)
);

// File: tb/wdt_timer_test.sv
`timescale 1ns/1ps
module wdt_timer_test;
    logic       clk = 1'b0;
    logic       rst_n, wdt_strobe, mode_wr_en, halt_mode, stop_mode, rc_tick, xtal_tick;
    logic [7:0] mode_wr_data, mode_rd_data;
    logic       reset_req;

    int n_vec = 0;
    int n_bad = 0;

    // Reference state, after the last edge.
    logic       m_armed, m_req;
    int         m_cnt, m_win;
    logic [4:0] m_mode;

    always #5 clk = ~clk;

    wdt_timer uut (
        .clk(clk), .rst_n(rst_n), .wdt_strobe(wdt_strobe), .mode_wr_en(mode_wr_en),
        .mode_wr_data(mode_wr_data), .mode_rd_data(mode_rd_data), .halt_mode(halt_mode),
        .stop_mode(stop_mode), .rc_tick(rc_tick), .xtal_tick(xtal_tick), .reset_req(reset_req)
    );

    // Terminal length from R5.
    function automatic int tap_len(input logic [4:0] md);
        int xt [4] = '{256, 512, 1024, 4096};
        int rc [4] = '{50, 150, 250, 1000};
        return md[4] ? xt[md[1:0]] : rc[md[1:0]];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle: drive, advance the model per R1..R10, compare at the negedge.
    task automatic cyc(input logic rn, input logic st, input logic we, input logic [7:0] wd,
                       input logic hl, input logic sp, input logic rc, input logic xt);
        logic run;
        rst_n = rn; wdt_strobe = st; mode_wr_en = we; mode_wr_data = wd;
        halt_mode = hl; stop_mode = sp; rc_tick = rc; xtal_tick = xt;
        @(posedge clk);
        if (!rn) begin
            m_armed = 0; m_cnt = 0; m_req = 0; m_mode = 5'b01101; m_win = 0;
        end else begin
            run   = m_armed && (m_mode[4] ? xt : rc) && (!hl || m_mode[2]) && (!sp || m_mode[3]);
            m_req = 0;
            if (st) begin
                m_armed = 1; m_cnt = 0;
            end else if (run) begin
                if (m_cnt + 1 == tap_len(m_mode)) begin
                    m_req = 1; m_armed = 0; m_cnt = 0;
                end else m_cnt++;
            end
            if (we && m_win < 64) m_mode = wd[4:0];
            if (m_win < 64) m_win++;
        end
        @(negedge clk);
        chk("R4 reset_req", reset_req, m_req);
        chk("R9 mode_rd", mode_rd_data, {3'b111, m_mode});
    endtask

    task automatic idle(input int n, input logic hl, input logic sp, input logic rc, input logic xt);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 8'h00, hl, sp, rc, xt);
    endtask

    // Power-on reset, then a write at edge 0 when wr is set.
    task automatic por(input logic wr, input logic [7:0] val);
        cyc(0, 0, 0, 8'h00, 0, 0, 0, 0);
        cyc(0, 0, 0, 8'h00, 0, 0, 0, 0);
        cyc(1, 0, wr, val, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        // R1: reset state
        cyc(0, 0, 0, 8'h00, 0, 0, 0, 0);
        chk("R1 reset mode", mode_rd_data, 8'hED);
        chk("R1 reset req", reset_req, 0);

        // R10: crystal, tap 00, both runs on; upper bits written 0 read 1
        por(1, 8'h1C);
        chk("R10 upper ones", mode_rd_data, 8'hFC);
        // R2: disarmed, ticks ignored
        idle(600, 0, 0, 1, 1);
        chk("R2 no req while disarmed", reset_req, 0);
        // R4/R5: 256 crystal ticks to fire
        cyc(1, 1, 0, 8'h00, 0, 0, 0, 0);
        idle(255, 0, 0, 0, 1);
        chk("R5 before 256", reset_req, 0);
        idle(1, 0, 0, 0, 1);
        chk("R4 fires at 256", reset_req, 1);
        idle(1, 0, 0, 0, 1);
        chk("R4 one-cycle pulse", reset_req, 0);
        idle(300, 0, 0, 0, 1);
        chk("R4 disarmed after fire", reset_req, 0);
        // R3: strobe together with the terminal tick
        cyc(1, 1, 0, 8'h00, 0, 0, 0, 0);
        idle(255, 0, 0, 0, 1);
        cyc(1, 1, 0, 8'h00, 0, 0, 0, 1);
        chk("R3 strobe beats terminal", reset_req, 0);
        idle(255, 0, 0, 0, 1);
        chk("R3 restart full count", reset_req, 0);
        idle(1, 0, 0, 0, 1);
        chk("R3 fires after restart", reset_req, 1);

        // R7/R8: crystal tap 00 with halt-run and stop-run cleared
        por(1, 8'h10);
        chk("R10 read F0", mode_rd_data, 8'hF0);
        cyc(1, 1, 0, 8'h00, 0, 0, 0, 0);
        idle(600, 1, 0, 0, 1);
        chk("R7 halt freezes", reset_req, 0);
        idle(600, 0, 1, 0, 1);
        chk("R8 stop freezes", reset_req, 0);
        idle(256, 0, 0, 0, 1);
        chk("R7 resumes after halt", reset_req, 1);

        // R6: RC source tap 00 (50), crystal ticks ignored
        por(1, 8'h0C);
        cyc(1, 1, 0, 8'h00, 0, 0, 0, 0);
        idle(200, 0, 0, 0, 1);
        chk("R6 crystal ignored", reset_req, 0);
        idle(49, 0, 0, 1, 1);
        chk("R6 rc 49", reset_req, 0);
        idle(1, 0, 0, 1, 0);
        chk("R6 rc 50 fires", reset_req, 1);

        // R9: last write edge 63 is taken, edge 64 is ignored
        por(0, 8'h00);
        idle(62, 0, 0, 0, 0);
        cyc(1, 0, 1, 8'h01, 0, 0, 0, 0);
        chk("R9 edge 63 accepted", mode_rd_data, 8'hE1);
        cyc(1, 0, 1, 8'h1F, 0, 0, 0, 0);
        chk("R9 edge 64 ignored", mode_rd_data, 8'hE1);

        // Random sessions against the model.
        for (int s = 0; s < 12; s++) begin
            int sprob;
            sprob = 200 + ($urandom % 3000);
            por(0, 8'h00);
            for (int c = 0; c < 3000; c++) begin
                cyc(1, ($urandom % sprob) == 0, ($urandom % 8) == 0, 8'($urandom),
                    ($urandom % 6) == 0, ($urandom % 7) == 0,
                    ($urandom % 3) == 0, ($urandom % 2) == 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule